// File: doc/BRIEF.md
# Two-Axis Display RAM Address Walker

This block keeps the write/read pointer for a display memory. The memory has 64 lines by 10 pages, plus one extra flag line. The pointer has two parts: a 6-bit line coordinate (0 to 63) and a 4-bit page coordinate (0 to 9). Every display-data access produces one step pulse. On that pulse the chosen primary axis moves one position up or down. When the primary axis runs off either end, it wraps around, and it carries into the other axis or borrows from it. The other axis also wraps within its own range.

Host commands reach the block as load strobes:
- A line load sets the line coordinate.
- A page load sets the page coordinate and also sets or clears flag mode.
- A mode write selects the primary axis and the direction.

In flag mode the block points at the flag line, which is line index 64. Only the page coordinate moves, whatever axis was selected. The memory array itself sits outside this block. It consumes `line_addr`, `page_addr` and `flag_sel`.

Top module: `ram_addr_walker`

## Requirements
- R1: After synchronous reset, line coordinate = 0, page = 0 and flag mode is off. The mode is page-primary, counting up. A step straight out of reset therefore moves the page to 1.
- R2: `ld_x` loads `ld_x_val` into the line coordinate. `ld_page` loads `ld_page_val` into the page coordinate and loads `ld_flag` into flag mode. A page value above 9 is stored as 9, so `page_addr` never exceeds 9. Results appear one cycle after the strobe.
- R3: Page-primary stepping (`mode_pg_sel`=1) moves the page by ±1 and leaves the line unchanged. Exception: up from page 9 gives page 0 and line+1, and down from page 0 gives page 9 and line−1.
- R4: Line-primary stepping (`mode_pg_sel`=0) moves the line by ±1 and leaves the page unchanged. Exception: up from line 63 gives line 0 and page+1, and down from line 0 gives line 63 and page−1.
- R5: A carry or borrow into the secondary axis wraps that axis modulo its own range: line 63+1 = 0, line 0−1 = 63, page 9+1 = 0, page 0−1 = 9.
- R6: In flag mode, `flag_sel`=1 and `line_addr`=64. Steps always move the page coordinate, even when line-primary is selected. A page wrap leaves the stored line coordinate unchanged. That line value shows again once flag mode is cleared.
- R7: A step in a cycle that also carries `ld_x`, `ld_page` or `mode_wr` is ignored. Without a step or load, all outputs hold.
- R8: `mode_wr` latches `mode_pg_sel` (1 = page axis primary) and `mode_up` (1 = up). The new mode applies to the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_x | input | 1 | Line coordinate load strobe |
| ld_x_val | input | 6 | Line value to load |
| ld_page | input | 1 | Page load strobe (also loads flag mode) |
| ld_page_val | input | 4 | Page value to load, clamped to 9 |
| ld_flag | input | 1 | Flag-mode bit loaded with the page |
| mode_wr | input | 1 | Mode write strobe |
| mode_pg_sel | input | 1 | 1 = page axis primary, 0 = line axis primary |
| mode_up | input | 1 | 1 = count up, 0 = count down |
| step | input | 1 | One pulse per display-data access |
| line_addr | output | 7 | Line index, 0..63 or 64 in flag mode |
| page_addr | output | 4 | Page index 0..9 |
| flag_sel | output | 1 | Flag line is addressed |

## Verification
The four axis and direction combinations are each stepped twice: once from an interior value, which shows a plain ±1 with the other axis still, and once from each end, which shows the carry or borrow. A corner where both axes wrap together (line 63, page 9, counting up) separates a correct modulo carry from an overflow. Flag mode is tried with line-primary selected and with a page wrap, to show that the page axis still moves and the stored line stays put. Out-of-range page loads, and steps that coincide with loads, cover the clamp and the step-suppression rules.

// File: rtl/addr_walk_pkg.sv
package addr_walk_pkg;

    localparam int unsigned LINES     = 64;
    localparam int unsigned PAGES     = 10;
    localparam int unsigned XW        = $clog2(LINES);
    localparam int unsigned PW        = $clog2(PAGES);
    localparam int unsigned LW        = $clog2(LINES + 1);
    localparam int unsigned FLAG_LINE = LINES;

    typedef enum logic {
        AX_LINE = 1'b0,
        AX_PAGE = 1'b1
    } axis_e;

    typedef struct packed {
        axis_e prim;
        logic  up;
        logic  flag;
    } walk_mode_t;

    localparam walk_mode_t MODE_RESET = '{prim: AX_PAGE, up: 1'b1, flag: 1'b0};

    function automatic axis_e effective_axis(input walk_mode_t m);
        return m.flag ? AX_PAGE : m.prim;
    endfunction

endpackage

// File: rtl/wrap_step.sv
module wrap_step #(
    parameter int unsigned W    = 6,
    parameter int unsigned LAST = 63
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    input  logic         go,
    output logic [W-1:0] nxt,
    output logic         at_edge
);
    localparam logic [W-1:0] LAST_V = W'(LAST);
    localparam logic [W-1:0] ONE_V  = W'(1);

    // Edge detection ignores go so a neighbour can use it without a loop.
    always_comb begin
        at_edge = up ? (cur == LAST_V) : (cur == '0);
        nxt     = cur;
        if (go) begin
            if (up) nxt = at_edge ? '0 : cur + ONE_V;
            else    nxt = at_edge ? LAST_V : cur - ONE_V;
        end
    end
endmodule

// File: rtl/page_clamp.sv
module page_clamp #(
    parameter int unsigned W    = 4,
    parameter int unsigned LAST = 9
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] safe
);
    localparam logic [W-1:0] LAST_V = W'(LAST);

    always_comb safe = (raw > LAST_V) ? LAST_V : raw;
endmodule

// File: rtl/walk_steer.sv
module walk_steer
    import addr_walk_pkg::*;
(
    input  logic       step,
    input  logic       any_ld,
    input  walk_mode_t mode,
    input  logic       x_edge,
    input  logic       pg_edge,
    output logic       x_go,
    output logic       pg_go
);
    axis_e eff;
    logic  step_ok;

    always_comb begin
        eff     = effective_axis(mode);
        step_ok = step && !any_ld;
        pg_go   = step_ok && ((eff == AX_PAGE) || (eff == AX_LINE && x_edge));
        x_go    = step_ok && ((eff == AX_LINE) ||
                              (eff == AX_PAGE && pg_edge && !mode.flag));
    end
endmodule

// File: rtl/ram_addr_walker.sv
module ram_addr_walker
    import addr_walk_pkg::*;
#(
    parameter int unsigned N_LINES = LINES,
    parameter int unsigned N_PAGES = PAGES,
    localparam int unsigned XBITS  = $clog2(N_LINES),
    localparam int unsigned PBITS  = $clog2(N_PAGES),
    localparam int unsigned LBITS  = $clog2(N_LINES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_x,
    input  logic [XBITS-1:0] ld_x_val,
    input  logic             ld_page,
    input  logic [PBITS-1:0] ld_page_val,
    input  logic             ld_flag,
    input  logic             mode_wr,
    input  logic             mode_pg_sel,
    input  logic             mode_up,
    input  logic             step,
    output logic [LBITS-1:0] line_addr,
    output logic [PBITS-1:0] page_addr,
    output logic             flag_sel
);
    localparam logic [LBITS-1:0] FLAG_IDX = LBITS'(N_LINES);

    logic [XBITS-1:0] x_q, x_nxt;
    logic [PBITS-1:0] pg_q, pg_nxt, pg_load;
    walk_mode_t       mode_q;
    logic             x_edge, pg_edge, x_go, pg_go, any_ld;

    assign any_ld = ld_x || ld_page || mode_wr;

    walk_steer u_steer (
        .step    (step),
        .any_ld  (any_ld),
        .mode    (mode_q),
        .x_edge  (x_edge),
        .pg_edge (pg_edge),
        .x_go    (x_go),
        .pg_go   (pg_go)
    );

    wrap_step #(.W(XBITS), .LAST(N_LINES - 1)) u_x_step (
        .cur     (x_q),
        .up      (mode_q.up),
        .go      (x_go),
        .nxt     (x_nxt),
        .at_edge (x_edge)
    );

    wrap_step #(.W(PBITS), .LAST(N_PAGES - 1)) u_pg_step (
        .cur     (pg_q),
        .up      (mode_q.up),
        .go      (pg_go),
        .nxt     (pg_nxt),
        .at_edge (pg_edge)
    );

    page_clamp #(.W(PBITS), .LAST(N_PAGES - 1)) u_clamp (
        .raw  (ld_page_val),
        .safe (pg_load)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            pg_q   <= '0;
            mode_q <= MODE_RESET;
        end else begin
            if (ld_x) x_q <= ld_x_val;
            else      x_q <= x_nxt;
            if (ld_page) begin
                pg_q        <= pg_load;
                mode_q.flag <= ld_flag;
            end else begin
                pg_q <= pg_nxt;
            end
            if (mode_wr) begin
                mode_q.prim <= mode_pg_sel ? AX_PAGE : AX_LINE;
                mode_q.up   <= mode_up;
            end
        end
    end

    always_comb begin
        line_addr = mode_q.flag ? FLAG_IDX : LBITS'(x_q);
        page_addr = pg_q;
        flag_sel  = mode_q.flag;
    end
endmodule

// File: rtl/addr_walk_chk.sv
module addr_walk_chk (
    input logic       clk,
    input logic       rst,
    input logic       step,
    input logic       ld_x,
    input logic       ld_page,
    input logic [3:0] ld_page_val,
    input logic       mode_wr,
    input logic       pg_prim,
    input logic       up,
    input logic [6:0] line_addr,
    input logic [3:0] page_addr,
    input logic       flag_sel
);
    logic quiet_step;
    assign quiet_step = step && !ld_x && !ld_page && !mode_wr;

    // R2
    page_range_chk: assert property (@(posedge clk) disable iff (rst)
        page_addr <= 4'd9);

    // R2
    page_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        ld_page && ld_page_val > 4'd9 |=> page_addr == 4'd9);

    // R6
    flag_line_chk: assert property (@(posedge clk) disable iff (rst)
        flag_sel |-> line_addr == 7'd64);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step && !ld_x && !ld_page && !mode_wr |=>
        $stable(line_addr) && $stable(page_addr) && $stable(flag_sel));

    // R3
    pg_up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        quiet_step && pg_prim && up && !flag_sel && page_addr == 4'd9 |=>
        page_addr == 4'd0 && line_addr[5:0] == $past(line_addr[5:0]) + 6'd1);

    // R4
    x_up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        quiet_step && !pg_prim && up && !flag_sel && line_addr == 7'd63 |=>
        line_addr == 7'd0 &&
        page_addr == (($past(page_addr) == 4'd9) ? 4'd0 : $past(page_addr) + 4'd1));

    // R4
    x_dn_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        quiet_step && !pg_prim && !up && !flag_sel && line_addr == 7'd0 |=>
        line_addr == 7'd63 &&
        page_addr == (($past(page_addr) == 4'd0) ? 4'd9 : $past(page_addr) - 4'd1));
endmodule

bind ram_addr_walker addr_walk_chk u_walk_chk (
    .clk         (clk),
    .rst         (rst),
    .step        (step),
    .ld_x        (ld_x),
    .ld_page     (ld_page),
    .ld_page_val (ld_page_val),
    .mode_wr     (mode_wr),
    .pg_prim     (mode_q.prim == addr_walk_pkg::AX_PAGE),
    .up          (mode_q.up),
    .line_addr   (line_addr),
    .page_addr   (page_addr),
    .flag_sel    (flag_sel)
);

// File: tb/tb_ram_addr_walker.sv
module tb_ram_addr_walker;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_x = 1'b0, ld_page = 1'b0, ld_flag = 1'b0;
    logic [5:0] ld_x_val = '0;
    logic [3:0] ld_page_val = '0;
    logic       mode_wr = 1'b0, mode_pg_sel = 1'b0, mode_up = 1'b0, step = 1'b0;
    logic [6:0] line_addr;
    logic [3:0] page_addr;
    logic       flag_sel;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        int    line;
        int    page;
        bit    flag;
        string tag;
    } exp_t;

    exp_t q[$];

    int mx, mp;
    bit mf, msel, mup;

    always #2 clk = ~clk;

    ram_addr_walker dut (
        .clk(clk), .rst(rst),
        .ld_x(ld_x), .ld_x_val(ld_x_val),
        .ld_page(ld_page), .ld_page_val(ld_page_val), .ld_flag(ld_flag),
        .mode_wr(mode_wr), .mode_pg_sel(mode_pg_sel), .mode_up(mode_up),
        .step(step),
        .line_addr(line_addr), .page_addr(page_addr), .flag_sel(flag_sel)
    );

    // One cycle of stimulus plus the expected outputs after the next edge.
    task automatic cyc(input bit r, input bit stp,
                       input bit lx, input int xv,
                       input bit lp, input int pv, input bit lf,
                       input bit mw, input bit ms, input bit mu,
                       input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; step = stp;
        ld_x = lx; ld_x_val = 6'(xv);
        ld_page = lp; ld_page_val = 4'(pv); ld_flag = lf;
        mode_wr = mw; mode_pg_sel = ms; mode_up = mu;
        if (r) begin
            mx = 0; mp = 0; mf = 0; msel = 1; mup = 1;
        end else begin
            if (lx) mx = xv;
            if (lp) begin mp = (pv > 9) ? 9 : pv; mf = lf; end
            if (mw) begin msel = ms; mup = mu; end
            if (stp && !(lx || lp || mw)) begin
                if (mf || msel) begin
                    if (mup) begin
                        if (mp == 9) begin mp = 0; if (!mf) mx = (mx + 1) % 64; end
                        else mp = mp + 1;
                    end else begin
                        if (mp == 0) begin mp = 9; if (!mf) mx = (mx + 63) % 64; end
                        else mp = mp - 1;
                    end
                end else begin
                    if (mup) begin
                        if (mx == 63) begin mx = 0; mp = (mp + 1) % 10; end
                        else mx = mx + 1;
                    end else begin
                        if (mx == 0) begin mx = 63; mp = (mp + 9) % 10; end
                        else mx = mx - 1;
                    end
                end
            end
        end
        e.line = mf ? 64 : mx;
        e.page = mp;
        e.flag = mf;
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic stp(input string tag);
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic setx(input int v, input string tag);
        cyc(0, 0, 1, v, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic setp(input int v, input bit f, input string tag);
        cyc(0, 0, 0, 0, 1, v, f, 0, 0, 0, tag);
    endtask
    task automatic setm(input bit pg, input bit up, input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, pg, up, tag);
    endtask

    // Monitor: compare each expected item just after the edge that makes it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (line_addr !== 7'(e.line) || page_addr !== 4'(e.page) ||
                    flag_sel !== e.flag) begin
                    errors++;
                    $display("FAIL %s: got line=%0d page=%0d flag=%0d exp line=%0d page=%0d flag=%0d",
                             e.tag, line_addr, page_addr, flag_sel, e.line, e.page, e.flag);
                end
            end
        end
    end

    initial begin
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 reset");
        cyc(1, 1, 1, 7, 0, 0, 0, 0, 0, 0, "R1 reset over load");
        stp("R1 default page up");
        // R2 loads and clamp
        setx(5, "R2 line load");
        setp(3, 0, "R2 page load");
        setp(12, 0, "R2 clamp 12");
        setp(15, 0, "R2 clamp 15");
        // R3 page-primary
        stp("R3 page up wrap carries line");
        stp("R3 page interior up");
        setm(1, 0, "R8 mode page down");
        stp("R3 page interior down");
        stp("R3 page down wrap borrows line");
        // R4/R5 line-primary
        setm(0, 1, "R8 mode line up");
        setx(10, "R4 setup");
        stp("R4 line interior up");
        setx(63, "R4 setup");
        setp(9, 0, "R4 setup");
        stp("R5 double wrap up");
        setm(0, 0, "R8 mode line down");
        stp("R5 double wrap down");
        setx(20, "R4 setup");
        stp("R4 line interior down");
        // R6 flag mode
        setm(0, 1, "R6 setup");
        setp(4, 1, "R6 flag on");
        stp("R6 line select steps page");
        setp(9, 1, "R6 flag at 9");
        stp("R6 page wrap leaves line");
        setp(2, 0, "R6 flag off line restored");
        // R7 step suppressed by loads
        cyc(0, 1, 1, 30, 0, 0, 0, 0, 0, 0, "R7 step with line load");
        cyc(0, 1, 0, 0, 1, 6, 0, 0, 0, 0, "R7 step with page load");
        cyc(0, 1, 0, 0, 0, 0, 0, 1, 1, 1, "R7 step with mode write");
        idle("R7 idle hold");
        stp("R8 new mode page up");
        idle("R7 idle hold");
        idle("R7 drain");
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule